// File: doc/BRIEF.md
# 64-bit SECDED Memory Word Guard

This block sits between a memory controller and the storage array. It protects each 64-bit data word with an extended Hamming code that adds 8 check bits, so 72 bits are stored. On the write side it turns a data word into the 72-bit stored form. On the read side it takes the 72 bits that come back from storage and computes a syndrome and an overall parity. It repairs any single flipped bit and flags words with two flipped bits, which it cannot repair. The result appears one clock after the read is presented.

When scrubbing is enabled, a repaired read produces a write-back request. The request carries the read address and the freshly re-encoded repaired word. The controller writes it back to storage and acknowledges it. Two saturating statistics counters track repaired and unrepairable reads. Both counters share a synchronous clear.

Top module: `ecc72_guard`

## Requirements
- R1: `wr_code` is the combinational encoding of `wr_data`. Bit 0 makes the XOR of all 72 bits zero. Check bit k sits at position 2^k for k = 0..6. Data bits 0..63 fill the remaining positions 3, 5, 6, 7, 9, ... 71 in ascending order. The XOR of the indices of all set bits among positions 1..71 is zero.
- R2: `rsp_valid` is high exactly on the cycle after a cycle with `rd_valid` high, and low otherwise.
- R3: A read of an intact codeword returns its data with `rsp_corrected` and `rsp_uncorrectable` both low.
- R4: A read with any one of the 72 bits inverted returns the original data with `rsp_corrected` high and `rsp_uncorrectable` low. An error in bit 0 alone leaves the data unchanged.
- R5: A read is flagged `rsp_uncorrectable` (with `rsp_corrected` low) in two cases. The first is any two inverted bits. The second is an overall parity mismatch whose syndrome points beyond position 71, for example bits 1, 32 and 64 inverted.
- R6: A repaired read with `scrub_en` high raises `scrub_req` on the next cycle. The request carries `scrub_addr` equal to the read address and `scrub_code` equal to the R1 encoding of the repaired data. It holds both stable until a cycle in which `scrub_ack` is high, and drops on the following cycle.
- R7: No write-back request is raised when `scrub_en` is low or when the read is unrepairable.
- R8: A repaired read that arrives while a request is outstanding leaves that request's address and code unchanged.
- R9: `corr_count` counts repaired responses and `uncorr_count` counts unrepairable responses, one step per response. Each saturates at 2^CNT_W-1.
- R10: `cnt_clr` high sets both counters to zero on the next cycle, even when an increment occurs in the same cycle.
- R11: After reset, `rsp_valid`, the response flags, `scrub_req` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 64 | Data word to be stored |
| wr_code | output | 72 | Encoded word for storage |
| rd_valid | input | 1 | A stored word is presented on rd_code |
| rd_addr | input | ADDR_W | Address the word was read from |
| rd_code | input | 72 | 72-bit word returned by storage |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 64 | Repaired read data |
| rsp_corrected | output | 1 | A single-bit error was repaired |
| rsp_uncorrectable | output | 1 | An unrepairable error was detected |
| scrub_en | input | 1 | Enables write-back requests |
| scrub_req | output | 1 | Write-back request outstanding |
| scrub_addr | output | ADDR_W | Write-back address |
| scrub_code | output | 72 | Re-encoded repaired word to write back |
| scrub_ack | input | 1 | Controller accepts the write-back |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| corr_count | output | CNT_W | Saturating count of repaired reads |
| uncorr_count | output | CNT_W | Saturating count of unrepairable reads |

## Verification
The assertions assume that the controller treats `scrub_ack` as meaningful only while `scrub_req` is high. They also assume that `rd_code` is only sampled when `rd_valid` is high. The bench pulses the acknowledge only while a request is outstanding. The bench's flips are limited to one bit (to reach repair) or to chosen sets of two or three bits (to reach detection), so every expected response falls into a class the code defines. Counters are built with a 3-bit width, so saturation is reached within the bench's short run.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;
  localparam int DATA_W = 64;
  localparam int PAR_W  = 7;
  localparam int CODE_W = DATA_W + PAR_W + 1;
  localparam int TOP_POS = CODE_W - 1;

  // position p carries a check bit when it is a power of two
  function automatic logic pos_is_check(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // place data bits into the non-check positions, ascending
  function automatic logic [CODE_W-1:0] spread(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= TOP_POS; p++) begin
      if (!pos_is_check(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    return c;
  endfunction

  // pull data bits back out of the non-check positions
  function automatic logic [DATA_W-1:0] gather(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= TOP_POS; p++) begin
      if (!pos_is_check(p)) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction

  // XOR of the indices of all set bits in positions 1..TOP_POS
  function automatic logic [PAR_W-1:0] syndrome(input logic [CODE_W-1:0] c);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int p = 1; p <= TOP_POS; p++) begin
      if (c[p]) s = s ^ PAR_W'(p);
    end
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic [PAR_W-1:0] s;
    c = spread(d);
    s = syndrome(c);
    for (int k = 0; k < PAR_W; k++) c[1 << k] = s[k];
    c[0] = ^c[TOP_POS:1];
    return c;
  endfunction
endpackage

// File: rtl/ecc72_encoder.sv
module ecc72_encoder
  import ecc72_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  assign code_o = encode(data_i);
endmodule

// File: rtl/ecc72_decoder.sv
module ecc72_decoder
  import ecc72_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              fatal_o
);
  logic [PAR_W-1:0]  syn;
  logic              par_bad;
  logic              syn_in_range;
  logic [CODE_W-1:0] flip_mask;

  assign syn          = syndrome(code_i);
  assign par_bad      = ^code_i;
  assign syn_in_range = (int'(syn) <= TOP_POS);

  // odd error count with a real position -> one flip (syn 0 = parity bit)
  assign single_o = par_bad && syn_in_range;
  // even count with nonzero syndrome, or odd count pointing nowhere
  assign fatal_o  = (!par_bad && (syn != '0)) || (par_bad && !syn_in_range);

  always_comb begin
    flip_mask = '0;
    if (single_o) flip_mask[syn] = 1'b1;
  end

  assign data_o = gather(code_i ^ flip_mask);
endmodule

// File: rtl/ecc72_sat_counter.sv
module ecc72_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAXV)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/ecc72_guard.sv
module ecc72_guard
  import ecc72_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] wr_code,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CODE_W-1:0] rd_code,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_corrected,
  output logic              rsp_uncorrectable,
  input  logic              scrub_en,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr,
  output logic [CODE_W-1:0] scrub_code,
  input  logic              scrub_ack,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  corr_count,
  output logic [CNT_W-1:0]  uncorr_count
);
  localparam int N_EV = 2;

  logic [DATA_W-1:0] dec_data;
  logic              dec_single;
  logic              dec_fatal;
  logic [CODE_W-1:0] fix_code;

  // named internal events
  logic              ev_fixed;
  logic              ev_fatal;
  logic              scrub_take;
  logic              scrub_done;
  logic [N_EV-1:0]   ev_bus;
  logic [CNT_W-1:0]  cnt_q [N_EV];

  ecc72_encoder u_wr_enc (.data_i(wr_data), .code_o(wr_code));

  ecc72_decoder u_dec (
    .code_i  (rd_code),
    .data_o  (dec_data),
    .single_o(dec_single),
    .fatal_o (dec_fatal)
  );

  ecc72_encoder u_fix_enc (.data_i(dec_data), .code_o(fix_code));

  assign ev_fixed   = rd_valid && dec_single;
  assign ev_fatal   = rd_valid && dec_fatal;
  assign scrub_take = ev_fixed && scrub_en && !scrub_req;
  assign scrub_done = scrub_req && scrub_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid         <= 1'b0;
      rsp_data          <= '0;
      rsp_corrected     <= 1'b0;
      rsp_uncorrectable <= 1'b0;
    end else begin
      rsp_valid         <= rd_valid;
      rsp_corrected     <= ev_fixed;
      rsp_uncorrectable <= ev_fatal;
      if (rd_valid) rsp_data <= dec_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
      scrub_code <= '0;
    end else if (scrub_done) begin
      scrub_req  <= 1'b0;
    end else if (scrub_take) begin
      scrub_req  <= 1'b1;
      scrub_addr <= rd_addr;
      scrub_code <= fix_code;
    end
  end

  assign ev_bus = {ev_fatal, ev_fixed};

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    ecc72_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr_i(cnt_clr),
      .inc_i(ev_bus[g]),
      .cnt_o(cnt_q[g])
    );
  end

  assign corr_count   = cnt_q[0];
  assign uncorr_count = cnt_q[1];
endmodule

// File: rtl/ecc72_guard_chk.sv
module ecc72_guard_chk
  import ecc72_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] wr_code,
  input logic              rd_valid,
  input logic              rsp_valid,
  input logic              rsp_corrected,
  input logic              rsp_uncorrectable,
  input logic              scrub_req,
  input logic [ADDR_W-1:0] scrub_addr,
  input logic [CODE_W-1:0] scrub_code,
  input logic              scrub_ack,
  input logic              ev_fixed,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  corr_count,
  input logic [CNT_W-1:0]  uncorr_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r1_wr_code_clean: assert property (@(posedge clk) disable iff (!rst_n)
    syndrome(wr_code) == '0 && (^wr_code) == 1'b0);

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

  a_r3_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_corrected || rsp_uncorrectable) |-> rsp_valid);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_corrected && rsp_uncorrectable));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req && !scrub_ack |=> scrub_req && $stable(scrub_addr) && $stable(scrub_code));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req && scrub_ack |=> !scrub_req);

  a_r6_code_clean: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> syndrome(scrub_code) == '0 && (^scrub_code) == 1'b0);

  a_r7_rise_needs_fix: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scrub_req) |-> $past(ev_fixed));

  a_r9_corr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> corr_count == $past(corr_count) || corr_count == $past(corr_count) + CNT_W'(1));

  a_r9_corr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr && corr_count == CMAX |=> corr_count == CMAX);

  a_r9_uncorr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr && uncorr_count == CMAX |=> uncorr_count == CMAX);

  a_r9_corr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fixed && !cnt_clr && corr_count != CMAX |=> corr_count == $past(corr_count) + CNT_W'(1));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> corr_count == '0 && uncorr_count == '0);
endmodule

bind ecc72_guard ecc72_guard_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_code          (wr_code),
  .rd_valid         (rd_valid),
  .rsp_valid        (rsp_valid),
  .rsp_corrected    (rsp_corrected),
  .rsp_uncorrectable(rsp_uncorrectable),
  .scrub_req        (scrub_req),
  .scrub_addr       (scrub_addr),
  .scrub_code       (scrub_code),
  .scrub_ack        (scrub_ack),
  .ev_fixed         (ev_fixed),
  .cnt_clr          (cnt_clr),
  .corr_count       (corr_count),
  .uncorr_count     (uncorr_count)
);

// File: tb/sim_ecc72_guard.sv
module sim_ecc72_guard;
  localparam int AW = 12;
  localparam int CW = 3;
  localparam int WATCH = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   wr_data = '0;
  logic [71:0]   wr_code;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [71:0]   rd_code = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          rsp_corrected, rsp_uncorrectable;
  logic          scrub_en = 1'b0;
  logic          scrub_req;
  logic [AW-1:0] scrub_addr;
  logic [71:0]   scrub_code;
  logic          scrub_ack = 1'b0;
  logic          cnt_clr = 1'b0;
  logic [CW-1:0] corr_count, uncorr_count;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] data;
    logic        corr;
    logic        unc;
    int          cyc;
    string       req;
  } exp_t;
  exp_t sb[$];

  ecc72_guard #(.ADDR_W(AW), .CNT_W(CW)) u0 (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference encoder, written independently of the design
  function automatic logic [71:0] ref_enc(input logic [63:0] d);
    logic [71:0] c;
    int p;
    c = '0;
    p = 1;
    for (int j = 0; j < 64; j++) begin
      while ((p & (p - 1)) == 0) p++;
      c[p] = d[j];
      p++;
    end
    for (int k = 0; k < 7; k++) begin
      logic b;
      b = 1'b0;
      for (int q = 1; q < 72; q++) if (((q >> k) & 1) == 1 && q != (1 << k)) b ^= c[q];
      c[1 << k] = b;
    end
    c[0] = ^c[71:1];
    return c;
  endfunction

  task automatic chk(input string req, input bit ok, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: present one read and queue what must come back
  task automatic do_read(input logic [71:0] code, input logic [AW-1:0] addr,
                         input logic [63:0] d, input logic c, input logic u,
                         input string req);
    exp_t e;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_code  = code;
    rd_addr  = addr;
    e.data = d; e.corr = c; e.unc = u; e.cyc = cyc; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_valid = 1'b0;
    end
  endtask

  // monitor: compare each response with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid) begin
          if (sb.size() == 0) begin
            chk("R2", 0, "unexpected rsp_valid", 72'(rsp_valid), 72'(0));
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R2", e.cyc + 1 == cyc, "response cycle", 72'(cyc), 72'(e.cyc + 1));
            chk(e.req, rsp_data == e.data, "rsp_data", 72'(rsp_data), 72'(e.data));
            chk(e.req, rsp_corrected == e.corr, "rsp_corrected", 72'(rsp_corrected), 72'(e.corr));
            chk(e.req, rsp_uncorrectable == e.unc, "rsp_uncorrectable",
                72'(rsp_uncorrectable), 72'(e.unc));
          end
        end else if (sb.size() > 0 && sb[0].cyc + 1 == cyc) begin
          chk("R2", 0, "missing rsp_valid", 72'(0), 72'(1));
          void'(sb.pop_front());
        end
      end
    end
  end

  initial begin
    #(WATCH * 10);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCH);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  logic [63:0] pats [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0123_4567,
                            64'h8000_0000_0000_0001, 64'hA5A5_5A5A_C3C3_3C3C,
                            64'h0F1E_2D3C_4B5A_6978};

  initial begin
    logic [71:0] cw;
    logic [71:0] held;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", rsp_valid == 0 && rsp_corrected == 0 && rsp_uncorrectable == 0,
        "rsp outputs in reset", 72'({rsp_valid, rsp_corrected, rsp_uncorrectable}), 72'(0));
    chk("R11", scrub_req == 0, "scrub_req in reset", 72'(scrub_req), 72'(0));
    chk("R11", corr_count == 0 && uncorr_count == 0, "counters in reset",
        72'({corr_count, uncorr_count}), 72'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", rsp_valid == 0 && scrub_req == 0, "after release",
        72'({rsp_valid, scrub_req}), 72'(0));

    // R1: write-side encoding
    foreach (pats[i]) begin
      @(negedge clk);
      wr_data = pats[i];
      #1;
      chk("R1", wr_code == ref_enc(pats[i]), "wr_code", wr_code, ref_enc(pats[i]));
    end

    // R3: clean reads
    foreach (pats[i]) do_read(ref_enc(pats[i]), AW'(i), pats[i], 1'b0, 1'b0, "R3");
    idle(2);
    chk("R9", corr_count == 0 && uncorr_count == 0, "counts after clean reads",
        72'({corr_count, uncorr_count}), 72'(0));

    // R4: every single-bit position, scrubbing off
    cw = ref_enc(pats[2]);
    for (int p = 0; p < 3; p++) do_read(cw ^ (72'd1 << p), AW'(p), pats[2], 1'b1, 1'b0, "R4");
    idle(1);
    chk("R9", corr_count == 3, "corr_count step", 72'(corr_count), 72'(3));
    for (int p = 3; p < 72; p++) do_read(cw ^ (72'd1 << p), AW'(p), pats[2], 1'b1, 1'b0, "R4");
    idle(2);
    chk("R9", corr_count == 7, "corr_count saturates", 72'(corr_count), 72'(7));
    chk("R7", scrub_req == 0, "no request with scrub_en low", 72'(scrub_req), 72'(0));

    // R10: clear
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk("R10", corr_count == 0 && uncorr_count == 0, "after clear",
        72'({corr_count, uncorr_count}), 72'(0));

    // R5: double errors and a triple pointing out of range, with scrub on
    scrub_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      int a;
      int b;
      a = (i * 13) % 72;
      b = (i * 29 + 7) % 72;
      cw = ref_enc(pats[i]);
      do_read(cw ^ (72'd1 << a) ^ (72'd1 << b), AW'(i), gather_raw(cw ^ (72'd1 << a) ^ (72'd1 << b)),
              1'b0, 1'b1, "R5");
    end
    cw = ref_enc(pats[5]) ^ (72'd1 << 1) ^ (72'd1 << 32) ^ (72'd1 << 64);
    do_read(cw, AW'(9), gather_raw(cw), 1'b0, 1'b1, "R5");
    idle(2);
    chk("R9", uncorr_count == 6 && corr_count == 0, "uncorr_count",
        72'({uncorr_count, corr_count}), 72'({3'd6, 3'd0}));
    chk("R7", scrub_req == 0, "no request for uncorrectable", 72'(scrub_req), 72'(0));

    // R10: clear wins over a same-cycle increment
    scrub_en = 1'b0;
    cw = ref_enc(pats[1]);
    do_read(cw ^ (72'd1 << 40), AW'(1), pats[1], 1'b1, 1'b0, "R4");
    cnt_clr = 1'b1;
    @(negedge clk); rd_valid = 1'b0; cnt_clr = 1'b0;
    chk("R10", corr_count == 0 && uncorr_count == 0, "clear beats increment",
        72'({corr_count, uncorr_count}), 72'(0));

    // R6: write-back request
    scrub_en = 1'b1;
    cw = ref_enc(pats[3]);
    do_read(cw ^ (72'd1 << 17), AW'(12'h5A3), pats[3], 1'b1, 1'b0, "R6");
    idle(1);
    chk("R6", scrub_req == 1, "scrub_req raised", 72'(scrub_req), 72'(1));
    chk("R6", scrub_addr == AW'(12'h5A3), "scrub_addr", 72'(scrub_addr), 72'(12'h5A3));
    chk("R6", scrub_code == cw, "scrub_code", scrub_code, cw);
    held = scrub_code;
    // R8: another repaired read while outstanding
    do_read(ref_enc(pats[4]) ^ (72'd1 << 0), AW'(12'h011), pats[4], 1'b1, 1'b0, "R8");
    idle(3);
    chk("R8", scrub_addr == AW'(12'h5A3), "addr kept", 72'(scrub_addr), 72'(12'h5A3));
    chk("R8", scrub_code == held, "code kept", scrub_code, held);
    chk("R6", scrub_req == 1, "held without ack", 72'(scrub_req), 72'(1));
    @(negedge clk); scrub_ack = 1'b1;
    @(negedge clk); scrub_ack = 1'b0;
    chk("R6", scrub_req == 0, "dropped after ack", 72'(scrub_req), 72'(0));

    // R7: scrub_en low, repaired read, no request
    scrub_en = 1'b0;
    do_read(ref_enc(pats[5]) ^ (72'd1 << 71), AW'(3), pats[5], 1'b1, 1'b0, "R4");
    idle(2);
    chk("R7", scrub_req == 0, "no request with scrub_en low", 72'(scrub_req), 72'(0));

    idle(3);
    chk("R2", sb.size() == 0, "responses outstanding", 72'(sb.size()), 72'(0));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  // raw data bits of a stored word, no repair (bench's own extraction)
  function automatic logic [63:0] gather_raw(input logic [71:0] c);
    logic [63:0] d;
    int p;
    d = '0;
    p = 1;
    for (int j = 0; j < 64; j++) begin
      while ((p & (p - 1)) == 0) p++;
      d[j] = c[p];
      p++;
    end
    return d;
  endfunction
endmodule